// File: doc/BRIEF.md
# Regulator Fault and Thermal Supervisor

This block watches single-bit flags from external comparators around a multiphase core regulator and turns them into fault latches and a request to the power stage. It qualifies two over-current tiers with different hold times, latches over-voltage and under-voltage events, tracks a thermal warning with hysteresis, and latches a thermal shutdown. Threshold generation, analog sensing and gate drive belong to the surrounding logic.

Every flag passes through a synchronizer before any decision is made. The power stage reads a two-bit request: run normally, turn every switch off, or hold the low-side switch on with the high side off. Over-voltage wins over every other fault. The over-current, over-voltage and under-voltage latches clear on a controller restart (`ctl_reset`) or on the power-on reset (`rst_n`). The thermal shutdown latch clears only on `rst_n`, which models a full power cycle.

Top module: `reg_fault_supervisor`

## Requirements
- R1: `oc_flag` trips the over-current fault only after it has been high for OC_QUAL_CYCLES consecutive clocks (default 5000, i.e. 100 us at 50 MHz). A run one clock shorter trips nothing.
- R2: `sc_flag` trips the short-circuit fault after SC_QUAL_CYCLES consecutive clocks high (default 500, i.e. 10 us). A run one clock shorter trips nothing. The over-current limits do not depend on the number of active phases.
- R3: Any clock with a qualified flag low restarts its count from zero. Two runs one clock short of the limit, separated by a single low clock, trip nothing.
- R4: `gate_cmd` encodes 2'b00 = run, 2'b01 = all switches off, 2'b10 = low side on and high side off. An over-current or short-circuit fault gives 2'b01.
- R5: `ov_flag` sets a latched over-voltage fault giving `gate_cmd` = 2'b10, which persists after the flag falls.
- R6: `uv_flag` sets a latched under-voltage fault giving `gate_cmd` = 2'b01, which persists after the flag falls.
- R7: When over-voltage is latched together with any other fault, `gate_cmd` is 2'b10.
- R8: A one-clock `ctl_reset` pulse clears the over-current, short-circuit, over-voltage and under-voltage latches and the qualification counts. `gate_cmd` then returns to 2'b00 unless a thermal shutdown is latched.
- R9: `hot_o` rises when `tm_warn_flag` (input below 43 % of the rail) is seen. It stays high after that flag falls and clears only when `tm_clear_flag` (input above 50 %) is seen.
- R10: `tm_shdn_flag` (input below 32 %) drives `shdn_n_o` low and `gate_cmd` to 2'b01. Both hold through flag removal and `ctl_reset`, and only `rst_n` releases them.
- R11: While and after `rst_n` is asserted, `gate_cmd` = 2'b00, `hot_o` = 0 and `shdn_n_o` = 1.
- R12: An unqualified flag (`ov_flag`, `uv_flag`, thermal flags) set before clock edge k shows at the outputs after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; clears everything |
| ctl_reset | input | 1 | Synchronous controller restart; clears the electrical fault latches only |
| oc_flag | input | 1 | Current sense above the over-current level |
| sc_flag | input | 1 | Current sense above the short-circuit level |
| ov_flag | input | 1 | Feedback more than 390 mV above the reference |
| uv_flag | input | 1 | Feedback more than 300 mV below the reference |
| tm_warn_flag | input | 1 | Thermal input below the hot-warning level |
| tm_clear_flag | input | 1 | Thermal input above the hot-release level |
| tm_shdn_flag | input | 1 | Thermal input below the shutdown level |
| gate_cmd | output | 2 | Power stage request: 00 run, 01 all off, 10 low side on |
| hot_o | output | 1 | Hot warning with hysteresis |
| shdn_n_o | output | 1 | Active-low thermal shutdown indication |

## Verification
The bench holds each over-current flag for exactly one clock less than its limit and then for exactly the limit. A timer that is off by one either trips on the short run or never trips. A run broken by one low clock targets a counter that holds its value instead of restarting, which would trip early. Over-voltage is latched on top of an existing under-voltage fault to catch a priority chain that lets the all-off request win. The thermal tests release the warning flag without the release flag, and apply a controller restart after a shutdown, to expose hysteresis that collapses and a shutdown latch that clears too easily.

// File: rtl/reg_fault_pkg.sv
package reg_fault_pkg;
  typedef enum logic [1:0] {
    GATE_RUN     = 2'b00,
    GATE_ALL_OFF = 2'b01,
    GATE_LS_ON   = 2'b10
  } gate_req_e;

  localparam int unsigned FLAG_W   = 7;
  localparam int unsigned IDX_OC   = 0;
  localparam int unsigned IDX_SC   = 1;
  localparam int unsigned IDX_OV   = 2;
  localparam int unsigned IDX_UV   = 3;
  localparam int unsigned IDX_WARN = 4;
  localparam int unsigned IDX_CLR  = 5;
  localparam int unsigned IDX_SHDN = 6;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int unsigned LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trip_q, trip_d;
  logic          cnt_en;

  // Count only while the flag holds; any low clock restarts the run.
  assign cnt_en = flag_i && (cnt_q != LAST);

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (clr_i) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else begin
      if (!flag_i)     cnt_d = '0;
      else if (cnt_en) cnt_d = cnt_q + 1'b1;
      if (flag_i && (cnt_q == LAST)) trip_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

  assign trip_o = trip_q;

  // R1 / R2: a trip can only come on a clock where the flag is still high
  a_r1_trip_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(flag_i));
  // R3: a low flag restarts the qualification run
  a_r3_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_i |=> (cnt_q == '0));
  // R8: a restart clears the trip latch
  a_r8_clr_drops_trip: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !trip_q);
endmodule

// File: rtl/thermal_mon.sv
module thermal_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic release_i,
  input  logic shdn_i,
  output logic hot_o,
  output logic shdn_o
);
  logic hot_q, hot_d;
  logic shdn_q, shdn_d;

  always_comb begin
    hot_d = hot_q;
    if (warn_i)         hot_d = 1'b1;
    else if (release_i) hot_d = 1'b0;
    shdn_d = shdn_q | shdn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q  <= 1'b0;
      shdn_q <= 1'b0;
    end else begin
      hot_q  <= hot_d;
      shdn_q <= shdn_d;
    end
  end

  assign hot_o  = hot_q;
  assign shdn_o = shdn_q;

  // R9: without a release indication the warning holds
  a_r9_hot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_q && !release_i) |=> hot_q);
  // R10: shutdown never releases while power stays up
  a_r10_shdn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_q |=> shdn_q);
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import reg_fault_pkg::*;
#(
  parameter int unsigned OC_QUAL_CYCLES = 5000,
  parameter int unsigned SC_QUAL_CYCLES = 500,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_reset,
  input  logic       oc_flag,
  input  logic       sc_flag,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       tm_warn_flag,
  input  logic       tm_clear_flag,
  input  logic       tm_shdn_flag,
  output logic [1:0] gate_cmd,
  output logic       hot_o,
  output logic       shdn_n_o
);
  logic [FLAG_W-1:0] raw_flags, syn_flags;
  logic oc_trip, sc_trip, therm_shdn;
  logic ov_q, ov_d, uv_q, uv_d;
  gate_req_e gate_req;

  assign raw_flags = {tm_shdn_flag, tm_clear_flag, tm_warn_flag,
                      uv_flag, ov_flag, sc_flag, oc_flag};

  flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_flags), .sync_o(syn_flags));

  qual_timer #(.LIMIT(OC_QUAL_CYCLES)) u_oc_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(ctl_reset),
    .flag_i(syn_flags[IDX_OC]), .trip_o(oc_trip));

  qual_timer #(.LIMIT(SC_QUAL_CYCLES)) u_sc_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(ctl_reset),
    .flag_i(syn_flags[IDX_SC]), .trip_o(sc_trip));

  thermal_mon u_therm (
    .clk(clk), .rst_n(rst_n),
    .warn_i(syn_flags[IDX_WARN]), .release_i(syn_flags[IDX_CLR]),
    .shdn_i(syn_flags[IDX_SHDN]),
    .hot_o(hot_o), .shdn_o(therm_shdn));

  always_comb begin
    if (ctl_reset) begin
      ov_d = 1'b0;
      uv_d = 1'b0;
    end else begin
      ov_d = ov_q | syn_flags[IDX_OV];
      uv_d = uv_q | syn_flags[IDX_UV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      uv_q <= uv_d;
    end
  end

  // Over-voltage must pull the output down through the low side, so it wins.
  always_comb begin
    if (ov_q)                                        gate_req = GATE_LS_ON;
    else if (oc_trip || sc_trip || uv_q || therm_shdn) gate_req = GATE_ALL_OFF;
    else                                             gate_req = GATE_RUN;
  end

  assign gate_cmd = gate_req;
  assign shdn_n_o = ~therm_shdn;

  // R5 / R7: latched over-voltage always asks for the low side on
  a_r7_ov_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> (gate_cmd == GATE_LS_ON));
  // R6: under-voltage holds until a restart
  a_r6_uv_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_q && !ctl_reset) |=> uv_q);
  // R4: a tripped current fault never lets the stage run
  a_r4_oc_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip || sc_trip) |-> (gate_cmd != GATE_RUN));
  // R10: shutdown indication is stable until power-on reset
  a_r10_shdn_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_o |=> !shdn_n_o);
endmodule

// File: tb/reg_fault_supervisor_tb_top.sv
module reg_fault_supervisor_tb_top;
  localparam int OCN = 5000;
  localparam int SCN = 500;

  logic clk = 1'b0;
  logic rst_n, ctl_reset;
  logic oc_flag, sc_flag, ov_flag, uv_flag, tm_warn_flag, tm_clear_flag, tm_shdn_flag;
  logic [1:0] gate_cmd;
  logic hot_o, shdn_n_o;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  reg_fault_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset),
    .oc_flag(oc_flag), .sc_flag(sc_flag), .ov_flag(ov_flag), .uv_flag(uv_flag),
    .tm_warn_flag(tm_warn_flag), .tm_clear_flag(tm_clear_flag),
    .tm_shdn_flag(tm_shdn_flag),
    .gate_cmd(gate_cmd), .hot_o(hot_o), .shdn_n_o(shdn_n_o));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); ctl_reset = 1'b1;
    @(posedge clk); @(negedge clk); ctl_reset = 1'b0;
    edges(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 gate after reset", gate_cmd, 0);
    check("R11 hot after reset", hot_o, 0);
    check("R11 shdn_n after reset", shdn_n_o, 1);
  endtask

  task automatic t_oc();
    @(negedge clk); oc_flag = 1'b1; edges(OCN - 1); oc_flag = 1'b0;
    edges(5);
    check("R1 oc short run ignored", gate_cmd, 0);
    oc_flag = 1'b1; edges(OCN); oc_flag = 1'b0;
    edges(5);
    check("R1 oc full run trips", gate_cmd, 1);
    check("R4 oc gives all off", gate_cmd, 1);
    restart();
    check("R8 restart clears oc", gate_cmd, 0);
  endtask

  task automatic t_sc();
    @(negedge clk); sc_flag = 1'b1; edges(SCN - 1); sc_flag = 1'b0;
    edges(5);
    check("R2 sc short run ignored", gate_cmd, 0);
    sc_flag = 1'b1; edges(SCN); sc_flag = 1'b0;
    edges(5);
    check("R2 sc full run trips", gate_cmd, 1);
    restart();
  endtask

  task automatic t_restart_count();
    @(negedge clk); oc_flag = 1'b1; edges(OCN - 1);
    oc_flag = 1'b0; edges(1);
    oc_flag = 1'b1; edges(OCN - 1); oc_flag = 1'b0;
    edges(5);
    check("R3 broken oc run no trip", gate_cmd, 0);
    sc_flag = 1'b1; edges(SCN - 1);
    sc_flag = 1'b0; edges(1);
    sc_flag = 1'b1; edges(SCN - 1); sc_flag = 1'b0;
    edges(5);
    check("R3 broken sc run no trip", gate_cmd, 0);
  endtask

  task automatic t_ov_uv();
    @(negedge clk); ov_flag = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R12 ov not seen after two edges", gate_cmd, 0);
    @(posedge clk); @(negedge clk);
    check("R12 ov seen after third edge", gate_cmd, 2);
    ov_flag = 1'b0; edges(6);
    check("R5 ov latched after flag drop", gate_cmd, 2);
    restart();
    check("R8 restart clears ov", gate_cmd, 0);
    uv_flag = 1'b1; edges(3); uv_flag = 1'b0; edges(6);
    check("R6 uv latched all off", gate_cmd, 1);
    ov_flag = 1'b1; edges(3); ov_flag = 1'b0; edges(3);
    check("R7 ov over uv", gate_cmd, 2);
    restart();
    check("R8 restart clears ov and uv", gate_cmd, 0);
  endtask

  task automatic t_hot();
    @(negedge clk); tm_warn_flag = 1'b1; edges(3);
    check("R9 hot set", hot_o, 1);
    tm_warn_flag = 1'b0; edges(6);
    check("R9 hot held after warn drop", hot_o, 1);
    check("R9 hot does not stop stage", gate_cmd, 0);
    tm_clear_flag = 1'b1; edges(3);
    check("R9 hot released", hot_o, 0);
    tm_clear_flag = 1'b0; edges(3);
    check("R9 hot stays clear", hot_o, 0);
  endtask

  task automatic t_shdn();
    @(negedge clk); tm_shdn_flag = 1'b1; edges(3);
    check("R10 shdn_n low", shdn_n_o, 0);
    check("R10 shdn all off", gate_cmd, 1);
    tm_shdn_flag = 1'b0; edges(5);
    restart();
    check("R10 shdn survives restart", shdn_n_o, 0);
    check("R10 gate off after restart", gate_cmd, 1);
    ov_flag = 1'b1; edges(3); ov_flag = 1'b0; edges(2);
    check("R7 ov over shutdown", gate_cmd, 2);
    rst_n = 1'b0; edges(2);
    check("R11 gate in reset", gate_cmd, 0);
    rst_n = 1'b1; edges(3);
    check("R10 power reset clears shdn", shdn_n_o, 1);
    check("R11 gate after power reset", gate_cmd, 0);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_reset = 1'b0;
    oc_flag = 1'b0; sc_flag = 1'b0; ov_flag = 1'b0; uv_flag = 1'b0;
    tm_warn_flag = 1'b0; tm_clear_flag = 1'b0; tm_shdn_flag = 1'b0;
    edges(3);
    rst_n = 1'b1;
    edges(2);
    t_reset();
    t_oc();
    t_sc();
    t_restart_count();
    t_ov_uv();
    t_hot();
    t_shdn();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule